// File: doc/BRIEF.md
# PHY Initialization Sync Sequencer

This block re-synchronizes a storage-interface PHY after its clock has changed, its clock was stopped and restarted, or its timing or function configuration was rewritten. Software writes one timing-control word that holds four phase lengths, two mode bits and a start bit. Writing the start bit launches a fixed-order strobe sequence. First a sync-enable pulse, then a quiet gap, then a sync-reset pulse, then a settle wait that includes a fixed trailing overhead. Each length counts bus-clock cycles.

While the sequence runs, the start bit reads back as 1. When the last settle cycle has elapsed it reads 0 again and a one-cycle completion pulse is raised. The phase lengths are captured when the sequence starts, so software may rewrite the word at any time without disturbing a sequence in flight. The two mode bits are plain storage that drive the PHY's slow-path bypass and SDIO selection directly.

Top module: `phy_sync_seq`

## Requirements
- R1: A write with bit 31 set while idle starts a sequence; `busy` and read bit 31 are 1 from the cycle after that write until the sequence ends, then read 0.
- R2: Phase lengths are packed in the control word as: bits 11:8 enable-pulse length, bits 7:4 gap length, bits 3:0 reset-pulse length, bits 15:12 settle length; they read back as written.
- R3: `sync_en` is high for exactly the enable length, starting in the first cycle after the start write; `sync_rst` then rises after the gap and stays high for exactly the reset length; the two strobes are never high together and never high while idle.
- R4: `busy` stays high for the sum of the four lengths plus EXTRA (default 8) cycles.
- R5: A length of 0 makes its phase take no cycles, and the following phase begins at once.
- R6: `done` is high for exactly one cycle, the cycle right after the last busy cycle.
- R7: Writes while busy update the readback of bits 15:0 but do not change the running sequence's phase lengths.
- R8: While busy, writing 0 to bit 31 does not abort the sequence and writing 1 does not restart it.
- R9: Bit 29 (slow-path bypass) and bit 28 (SDIO mode) are read/write bits that drive `slow_mode` and `sdio_mode`.
- R10: A synchronous active-low reset clears all fields and mode bits and leaves the block idle with both strobes and `done` low.
- R11: Bits 30 and 27:16 ignore writes and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word write data |
| rd_data | output | 32 | Control word readback, bit 31 reflects busy |
| sync_en | output | 1 | Sync-enable strobe to the PHY |
| sync_rst | output | 1 | Sync-reset strobe to the PHY |
| slow_mode | output | 1 | Slow-path bypass mode bit |
| sdio_mode | output | 1 | SDIO mode bit |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench drives length mixes that include all-zero, all-maximum and patterns with an empty enable phase or an empty reset phase; a design that failed to skip empty phases would stretch the sequence or raise a strobe for a cycle it should not. It rewrites the word mid-sequence with new lengths, with bit 31 cleared and with bit 31 set; a design that read lengths live would change the strobe timing, and one that honoured bit 31 while busy would end early or run long. It also resets in mid-sequence, where a design that kept stale state would leave a strobe or busy stuck high.

// File: rtl/phy_sync_seq.sv
module phy_sync_seq #(
  parameter int LEN_W = 4,
  parameter int EXTRA = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        sync_en,
  output logic        sync_rst,
  output logic        slow_mode,
  output logic        sdio_mode,
  output logic        busy,
  output logic        done
);
  localparam int NPH    = 4;
  localparam int FLD_W  = NPH * LEN_W;
  localparam int MAXTOT = NPH * ((1 << LEN_W) - 1) + EXTRA;
  localparam int CNT_W  = $clog2(MAXTOT + 1);
  localparam int B_GO   = 31;
  localparam int B_SLOW = 29;
  localparam int B_SDIO = 28;

  logic [FLD_W-1:0] cfg_q, lat_q;
  logic             slow_q, sdio_q, busy_q, done_q;
  logic [CNT_W-1:0] elapsed_q;
  logic [CNT_W-1:0] len_rst, len_gap, len_en, len_wait;
  logic [CNT_W-1:0] end_en, end_gap, end_rst, last_cyc;
  logic             start_req;

  assign len_rst  = CNT_W'(lat_q[LEN_W-1:0]);
  assign len_gap  = CNT_W'(lat_q[2*LEN_W-1:LEN_W]);
  assign len_en   = CNT_W'(lat_q[3*LEN_W-1:2*LEN_W]);
  assign len_wait = CNT_W'(lat_q[4*LEN_W-1:3*LEN_W]);

  assign end_en   = len_en;
  assign end_gap  = end_en + len_gap;
  assign end_rst  = end_gap + len_rst;
  assign last_cyc = end_rst + len_wait + CNT_W'(EXTRA - 1);

  assign start_req = wr_en && wr_data[B_GO] && !busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      lat_q     <= '0;
      slow_q    <= 1'b0;
      sdio_q    <= 1'b0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      elapsed_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (wr_en) begin
        cfg_q  <= wr_data[FLD_W-1:0];
        slow_q <= wr_data[B_SLOW];
        sdio_q <= wr_data[B_SDIO];
      end
      if (start_req) begin
        lat_q     <= wr_data[FLD_W-1:0];
        busy_q    <= 1'b1;
        elapsed_q <= '0;
      end else if (busy_q) begin
        if (elapsed_q == last_cyc) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          elapsed_q <= elapsed_q + 1'b1;
        end
      end
    end
  end

  assign sync_en   = busy_q && (elapsed_q < end_en);
  assign sync_rst  = busy_q && (elapsed_q >= end_gap) && (elapsed_q < end_rst);
  assign busy      = busy_q;
  assign done      = done_q;
  assign slow_mode = slow_q;
  assign sdio_mode = sdio_q;

  always_comb begin
    rd_data              = '0;
    rd_data[FLD_W-1:0]   = cfg_q;
    rd_data[B_SDIO]      = sdio_q;
    rd_data[B_SLOW]      = slow_q;
    rd_data[B_GO]        = busy_q;
  end

  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[B_GO] && !busy) |=> busy);
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(sync_en && sync_rst));
  p_strobe_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_en || sync_rst) |-> busy);
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  p_done_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_lat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(rst_n)) |-> $stable(lat_q));
endmodule

// File: tb/test_phy_sync_seq.sv
module test_phy_sync_seq;
  localparam int PERIOD = 10;
  localparam int WIN    = 80;
  localparam logic [15:0] VEC [6] = '{16'h0000, 16'h1111, 16'h3021,
                                       16'hFFFF, 16'h0500, 16'h0F0F};

  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        sync_en, sync_rst, slow_mode, sdio_mode, busy, done;
  int checks = 0, errors = 0;

  always #(PERIOD/2) clk = ~clk;

  phy_sync_seq i_phy_sync_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .sync_en(sync_en), .sync_rst(sync_rst),
    .slow_mode(slow_mode), .sdio_mode(sdio_mode), .busy(busy), .done(done));

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 rd_data", rd_data, 0);
    chk("R10 strobes/busy/done", {sync_en, sync_rst, busy, done}, 0);

    foreach (VEC[vi]) begin
      automatic logic [15:0] v = VEC[vi];
      automatic int en = v[11:8], gp = v[7:4], rs = v[3:0], wt = v[15:12];
      automatic int tot = en + gp + rs + wt + 8;
      automatic int n_en = 0, n_rs = 0, n_bz = 0, n_dn = 0;
      automatic int f_en = -1, f_rs = -1, f_dn = -1, bit31_0 = 0;
      @(negedge clk); wr_en = 1; wr_data = {16'h8000, v};
      @(negedge clk); wr_en = 0;
      for (int k = 0; k < WIN; k++) begin
        if (k == 0) bit31_0 = rd_data[31];
        if (sync_en)  begin n_en++; if (f_en < 0) f_en = k; end
        if (sync_rst) begin n_rs++; if (f_rs < 0) f_rs = k; end
        if (busy) n_bz++;
        if (done) begin n_dn++; if (f_dn < 0) f_dn = k; end
        @(negedge clk);
      end
      chk("R1 bit31 while busy", bit31_0, 1);
      chk("R1 bit31 after", rd_data[31], 0);
      chk("R2 readback", rd_data[15:0], v);
      chk("R4 busy length", n_bz, tot);
      chk("R3 R5 enable length", n_en, en);
      if (en > 0) chk("R3 enable first cycle", f_en, 0);
      chk("R3 R5 reset length", n_rs, rs);
      if (rs > 0) chk("R3 R5 reset start", f_rs, en + gp);
      chk("R6 done count", n_dn, 1);
      chk("R6 done cycle", f_dn, tot);
    end

    wr(32'h3000_0000);
    @(negedge clk);
    chk("R9 mode outputs", {slow_mode, sdio_mode}, 2'b11);
    chk("R9 readback", rd_data, 32'h3000_0000);
    wr(32'h4FFF_0000);
    chk("R11 unused bits", rd_data, 0);
    chk("R9 modes cleared", {slow_mode, sdio_mode}, 2'b00);

    begin
      automatic int n_bz = 0, n_en = 0, n_rs = 0, f_dn = -1, f_rs = -1;
      automatic logic [31:0] mid = '0;
      @(negedge clk); wr_en = 1; wr_data = 32'h8000_0222;
      @(negedge clk); wr_en = 0;
      for (int k = 0; k < 40; k++) begin
        if (busy) n_bz++;
        if (sync_en) n_en++;
        if (sync_rst) begin n_rs++; if (f_rs < 0) f_rs = k; end
        if (done && f_dn < 0) f_dn = k;
        if (k == 4) mid = rd_data;
        wr_en = (k == 3) || (k == 5);
        wr_data = (k == 3) ? 32'h0000_0F0F : 32'h8000_FFFF;
        @(negedge clk);
      end
      wr_en = 0;
      chk("R7 readback mid-run", mid, 32'h8000_0F0F);
      chk("R7 R8 busy length", n_bz, 14);
      chk("R7 enable length", n_en, 2);
      chk("R7 reset length", n_rs, 2);
      chk("R7 reset start", f_rs, 4);
      chk("R8 done cycle", f_dn, 14);
      chk("R8 readback after", rd_data, 32'h0000_FFFF);
    end

    wr(32'h8000_0F00);
    repeat (2) @(negedge clk);
    chk("R10 pre-reset sync_en", sync_en, 1);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    chk("R10 mid-run reset", {sync_en, sync_rst, busy, done}, 0);
    chk("R10 mid-run rd_data", rd_data, 0);
    repeat (3) @(negedge clk);
    chk("R10 stays idle", {sync_en, busy, done}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule